// File: doc/BRIEF.md
# Edge-Selectable Input Capture Bank

This block is a bank of input capture channels that share one free-running counter supplied from outside. Each channel resynchronises an external pin through a two-flop synchronizer and follows the settled pin level with a two-state level tracker. A two-bit select field per channel picks which transitions count: none, rising only, falling only, or both. On a counted transition the channel stores the current counter value in its capture register and raises a sticky flag. The flag drives an interrupt output when that channel's enable bit is set.

The highest-numbered channel is shared. A role bit decides whether its register is a capture register or a plain read/write compare value held for a neighbouring compare unit. Software reaches the block through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the address. The counter, the prescaler and any wide-access coherency buffering sit outside this block.

The level tracker in each channel has two states. LVL_LOW moves to LVL_HIGH on the RISE transition, taken when the synchronized pin reads 1. LVL_HIGH moves to LVL_LOW on the FALL transition, taken when the synchronized pin reads 0. Otherwise the state holds. The shared channel's role register has two states: ROLE_COMPARE (0) and ROLE_CAPTURE (1). A bus write to the role address moves it between them.

Top module: `edge_capture_bank`

## Requirements
- R1: After reset every capture register reads 0xFFFF. The flags, interrupt outputs, edge select, interrupt enables and role bit all read 0.
- R2: Edge select register (address 4) holds bits [2i+1:2i] for channel i, with 00 = disabled, 01 = rising only, 10 = falling only, 11 = either edge. A transition that is not selected neither captures nor sets the flag.
- R3: A selected pin transition applied between clock edges is captured on the third rising clock edge after it (two synchronizer flops plus the level-tracker register). The register (address i for channel i) then holds the count_in value sampled at that edge.
- R4: Every selected edge overwrites the capture register, even while the channel flag is already set.
- R5: Each capture sets flag bit i (flag register, address 6, and flag_o[i]). irq_o[i] is 1 exactly when flag bit i and enable bit i (address 5) are both 1.
- R6: Writing 1 to flag bit i at address 6 clears it, and writing 0 leaves it unchanged. If a capture and a clear land on the same clock edge, the flag ends up set.
- R7: Capture registers of channels 0 to NUM_CH-2 ignore bus writes.
- R8: With role bit (address 7, bit 0) at 0, the shared channel's register (address 3) is read/write, and its pin edges neither capture nor set its flag.
- R9: With role bit at 1, the shared channel captures like the others. Bus writes to its register are ignored unless freeze_i is 1, in which case they take effect.
- R10: All channels sample the same count_in in a given cycle, so simultaneous selected edges on several pins capture identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | CNT_W | Shared free-running count value |
| pin_in | input | NUM_CH | Asynchronous capture pins, one per channel |
| freeze_i | input | 1 | Test/freeze qualifier that unlocks writes to the shared register in capture role |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Combinational read data for bus_addr |
| flag_o | output | NUM_CH | Sticky capture flags |
| irq_o | output | NUM_CH | Interrupt requests, flag AND enable |

## Verification
A pin change is made just after a falling clock edge. The capture value and the flag are then due after the third rising edge. The bench records count_in one time unit after that edge, which is the value the design samples, and it reads the register and flag at the following falling edge. A register write is due after the single rising edge inside the write strobe and is read back at the next falling edge, and irq_o is checked combinationally one time unit after the enable or flag change. The capture-versus-clear collision places the write strobe over exactly the third rising edge after the pin change.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    typedef enum logic {
        ROLE_COMPARE = 1'b0,
        ROLE_CAPTURE = 1'b1
    } share_role_t;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_RISE = 2'b01;
    localparam logic [1:0] SEL_FALL = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_edge_fsm.sv
module ecap_edge_fsm
    import ecap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic [1:0] sel_i,
    input  logic       enable_i,
    output logic       hit_o
);
    lvl_state_t state_q, state_d;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (lvl_i) begin
                    state_d = LVL_HIGH;
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!lvl_i) begin
                    state_d = LVL_LOW;
                    fall    = 1'b1;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        unique case (sel_i)
            SEL_OFF:  hit_o = 1'b0;
            SEL_RISE: hit_o = enable_i && rise;
            SEL_FALL: hit_o = enable_i && fall;
            SEL_BOTH: hit_o = enable_i && (rise || fall);
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecap_ctrl.sv
module ecap_ctrl
    import ecap_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_we,
    input  logic                  ien_we,
    input  logic                  role_we,
    input  logic [2*NUM_CH-1:0]   sel_wdata,
    input  logic [NUM_CH-1:0]     ien_wdata,
    input  logic                  role_wdata,
    output logic [2*NUM_CH-1:0]   sel_o,
    output logic [NUM_CH-1:0]     ien_o,
    output share_role_t           role_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o <= '0;
            ien_o <= '0;
        end else begin
            if (sel_we) sel_o <= sel_wdata;
            if (ien_we) ien_o <= ien_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       role_o <= ROLE_COMPARE;
        else if (role_we) role_o <= role_wdata ? ROLE_CAPTURE : ROLE_COMPARE;
    end
endmodule

// File: rtl/ecap_store.sv
module ecap_store #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        hit_i,
    input  logic [CNT_W-1:0]         count_i,
    input  logic [NUM_CH-1:0]        clr_mask_i,
    input  logic                     shared_we_i,
    input  logic [CNT_W-1:0]         wdata_i,
    output logic [NUM_CH*CNT_W-1:0]  cap_flat_o,
    output logic [NUM_CH-1:0]        flag_o
);
    localparam int SH = NUM_CH - 1;

    logic [CNT_W-1:0] cap_q [NUM_CH];

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_cap
            if (i == SH) begin : g_shared
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)          cap_q[i] <= '1;
                    else if (hit_i[i])   cap_q[i] <= count_i;
                    else if (shared_we_i) cap_q[i] <= wdata_i;
                end
            end else begin : g_plain
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        cap_q[i] <= '1;
                    else if (hit_i[i]) cap_q[i] <= count_i;
                end
            end
            assign cap_flat_o[i*CNT_W +: CNT_W] = cap_q[i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_mask_i) | hit_i;
    end
endmodule

// File: rtl/edge_capture_bank.sv
module edge_capture_bank
    import ecap_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CNT_W    = 16,
    parameter int SYNC_LEN = 2,
    parameter int ADDR_W   = $clog2(NUM_CH + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              freeze_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] flag_o,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int SH = NUM_CH - 1;
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(NUM_CH + 2);
    localparam logic [ADDR_W-1:0] A_ROLE = ADDR_W'(NUM_CH + 3);
    localparam logic [ADDR_W-1:0] A_SH   = ADDR_W'(SH);

    logic [NUM_CH-1:0]       lvl_sync;
    logic [NUM_CH-1:0]       hit_eff;
    logic [2*NUM_CH-1:0]     sel_q;
    logic [NUM_CH-1:0]       ien_q;
    share_role_t             role_q;
    logic [NUM_CH*CNT_W-1:0] cap_flat;
    logic [NUM_CH-1:0]       clr_mask;
    logic                    shared_we;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic ch_en;
            if (i == SH) begin : g_en_sh
                assign ch_en = (role_q == ROLE_CAPTURE);
            end else begin : g_en_pl
                assign ch_en = 1'b1;
            end

            ecap_sync #(.STAGES(SYNC_LEN)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (pin_in[i]),
                .q_o   (lvl_sync[i])
            );

            ecap_edge_fsm u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_i    (lvl_sync[i]),
                .sel_i    (sel_q[2*i +: 2]),
                .enable_i (ch_en),
                .hit_o    (hit_eff[i])
            );
        end
    endgenerate

    ecap_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (bus_wr && bus_addr == A_SEL),
        .ien_we     (bus_wr && bus_addr == A_IEN),
        .role_we    (bus_wr && bus_addr == A_ROLE),
        .sel_wdata  (bus_wdata[2*NUM_CH-1:0]),
        .ien_wdata  (bus_wdata[NUM_CH-1:0]),
        .role_wdata (bus_wdata[0]),
        .sel_o      (sel_q),
        .ien_o      (ien_q),
        .role_o     (role_q)
    );

    assign clr_mask  = (bus_wr && bus_addr == A_FLG) ? bus_wdata[NUM_CH-1:0] : '0;
    assign shared_we = bus_wr && (bus_addr == A_SH) &&
                       ((role_q == ROLE_COMPARE) || freeze_i);

    ecap_store #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit_eff),
        .count_i     (count_in),
        .clr_mask_i  (clr_mask),
        .shared_we_i (shared_we),
        .wdata_i     (bus_wdata),
        .cap_flat_o  (cap_flat),
        .flag_o      (flag_o)
    );

    assign irq_o = flag_o & ien_q;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = cap_flat[i*CNT_W +: CNT_W];
        end
        if (bus_addr == A_SEL)  bus_rdata = CNT_W'(sel_q);
        if (bus_addr == A_IEN)  bus_rdata = CNT_W'(ien_q);
        if (bus_addr == A_FLG)  bus_rdata = CNT_W'(flag_o);
        if (bus_addr == A_ROLE) bus_rdata = CNT_W'(role_q);
    end
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CNT_W-1:0]         count_in,
    input logic                     freeze_i,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [NUM_CH-1:0]        bus_wbits,
    input logic [NUM_CH-1:0]        flag_o,
    input logic [NUM_CH-1:0]        irq_o,
    input logic [NUM_CH-1:0]        hit_eff,
    input logic [NUM_CH*CNT_W-1:0]  cap_flat,
    input logic                     role_bit
);
    localparam int SH = NUM_CH - 1;
    localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(NUM_CH + 2);

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~flag_o) == '0);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R3
            capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit_eff[i] |=> cap_flat[i*CNT_W +: CNT_W] == $past(count_in));
            // R6
            capture_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit_eff[i] |=> flag_o[i]);
            // R6
            flag_clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flag_o[i]) |-> $past(bus_wr && bus_addr == A_FLG && bus_wbits[i]));
            if (i != SH) begin : g_ro
                // R7
                readonly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !hit_eff[i] |=> $stable(cap_flat[i*CNT_W +: CNT_W]));
            end
        end
    endgenerate

    // R8
    shared_flag_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o[SH]) |-> $past(role_bit));

    // R9
    shared_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role_bit && !freeze_i && !hit_eff[SH]) |=> $stable(cap_flat[SH*CNT_W +: CNT_W]));
endmodule

bind edge_capture_bank ecap_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_ecap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_in  (count_in),
    .freeze_i  (freeze_i),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wbits (bus_wdata[NUM_CH-1:0]),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .hit_eff   (hit_eff),
    .cap_flat  (cap_flat),
    .role_bit  (role_q == ecap_pkg::ROLE_CAPTURE)
);

// File: tb/edge_capture_bank_test.sv
`timescale 1ns/1ps
module edge_capture_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam logic [2:0] A_SEL = 3'd4, A_IEN = 3'd5, A_FLG = 3'd6, A_ROLE = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cnt;
    logic [NCH-1:0] pins = '0;
    logic freeze = 1'b0;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] flag_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) cnt <= 16'h1000;
        else        cnt <= cnt + 16'd1;
    end

    edge_capture_bank uut (
        .clk(clk), .rst_n(rst_n), .count_in(cnt), .pin_in(pins),
        .freeze_i(freeze), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive_pins(input logic [NCH-1:0] v, output logic [15:0] at_cnt);
        @(negedge clk);
        pins = v;
        repeat (3) @(posedge clk);
        #1;
        at_cnt = cnt;
        @(negedge clk);
    endtask

    task automatic set_pin(input int ch, input logic v, output logic [15:0] at_cnt);
        logic [NCH-1:0] nv;
        nv = pins;
        nv[ch] = v;
        drive_pins(nv, at_cnt);
    endtask

    // {ch[1:0], sel[1:0], level, expect_hit}
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        {2'd0, 2'b01, 1'b1, 1'b1},
        {2'd0, 2'b01, 1'b0, 1'b0},
        {2'd1, 2'b10, 1'b1, 1'b0},
        {2'd1, 2'b10, 1'b0, 1'b1},
        {2'd2, 2'b11, 1'b1, 1'b1},
        {2'd2, 2'b11, 1'b0, 1'b1},
        {2'd0, 2'b00, 1'b1, 1'b0},
        {2'd0, 2'b00, 1'b0, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, t, t2, old;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NCH; i++) begin
            rd(3'(i), v); chk("R1 capture reset", v, 16'hFFFF);
        end
        rd(A_FLG, v);  chk("R1 flags reset", v, 16'h0000);
        rd(A_SEL, v);  chk("R1 select reset", v, 16'h0000);
        rd(A_ROLE, v); chk("R1 role reset", v, 16'h0000);
        chk("R1 irq reset", 16'(irq_o), 16'h0000);

        // R2 / R3 vector table
        for (int k = 0; k < NV; k++) begin
            int ch;
            logic [1:0] sel;
            logic lvl, hit;
            ch = int'(VEC[k][5:4]); sel = VEC[k][3:2]; lvl = VEC[k][1]; hit = VEC[k][0];
            wr(A_FLG, 16'h000F);
            wr(A_SEL, 16'({14'd0, sel} << (2*ch)));
            rd(3'(ch), old);
            set_pin(ch, lvl, t);
            rd(A_FLG, v);
            chk($sformatf("R2 flag vec %0d", k), 16'(v[ch]), 16'(hit));
            rd(3'(ch), v);
            chk($sformatf("R3 value vec %0d", k), v, hit ? t : old);
        end

        // R4 overwrite while flag set
        wr(A_FLG, 16'h000F);
        wr(A_SEL, 16'h0003);
        set_pin(0, 1'b1, t);
        set_pin(0, 1'b0, t2);
        rd(3'd0, v); chk("R4 newest edge kept", v, t2);
        rd(A_FLG, v); chk("R4 flag still set", 16'(v[0]), 16'h0001);

        // R5 interrupt gating
        chk("R5 irq off without enable", 16'(irq_o[0]), 16'h0000);
        wr(A_IEN, 16'h0001); #1;
        chk("R5 irq with enable", 16'(irq_o[0]), 16'h0001);
        wr(A_IEN, 16'h0000); #1;
        chk("R5 irq after disable", 16'(irq_o[0]), 16'h0000);

        // R6 write-one-to-clear
        wr(A_FLG, 16'h0000);
        rd(A_FLG, v); chk("R6 write zero keeps flag", 16'(v[0]), 16'h0001);
        wr(A_FLG, 16'h0001);
        rd(A_FLG, v); chk("R6 write one clears", 16'(v[0]), 16'h0000);
        // R6 capture and clear on the same edge
        @(negedge clk);
        pins[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_FLG; bus_wdata = 16'h0001;
        @(posedge clk); #1; t = cnt;
        @(negedge clk); bus_wr = 1'b0;
        rd(A_FLG, v); chk("R6 capture wins over clear", 16'(v[0]), 16'h0001);
        rd(3'd0, v);  chk("R6 value on collision", v, t);

        // R7 read-only channels
        rd(3'd1, old);
        wr(3'd1, 16'h5A5A);
        rd(3'd1, v); chk("R7 write ignored", v, old);

        // R8 compare role
        wr(A_FLG, 16'h000F);
        wr(3'd3, 16'h1234);
        rd(3'd3, v); chk("R8 compare write", v, 16'h1234);
        wr(A_SEL, 16'h00C0);
        set_pin(3, 1'b1, t);
        rd(3'd3, v); chk("R8 no capture in compare role", v, 16'h1234);
        rd(A_FLG, v); chk("R8 no flag in compare role", 16'(v[3]), 16'h0000);

        // R9 capture role
        wr(A_ROLE, 16'h0001);
        rd(A_ROLE, v); chk("R9 role readback", v, 16'h0001);
        set_pin(3, 1'b0, t);
        rd(3'd3, v); chk("R9 shared capture", v, t);
        rd(A_FLG, v); chk("R9 shared flag", 16'(v[3]), 16'h0001);
        wr(3'd3, 16'hABCD);
        rd(3'd3, v); chk("R9 write locked", v, t);
        freeze = 1'b1;
        wr(3'd3, 16'hABCD);
        freeze = 1'b0;
        rd(3'd3, v); chk("R9 write under freeze", v, 16'hABCD);

        // R10 simultaneous edges
        wr(A_FLG, 16'h000F);
        wr(A_SEL, 16'h00FF);
        drive_pins(~pins, t);
        for (int i = 0; i < NCH; i++) begin
            rd(3'(i), v); chk($sformatf("R10 same count ch%0d", i), v, t);
        end
        rd(A_FLG, v); chk("R10 all flags", v, 16'h000F);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule